// File: doc/BRIEF.md
# I2C Bus Activity Watcher

This block listens on the two wires of an I2C bus without ever driving them. A system clock that runs much faster than the bus samples both lines. Each line first passes through a synchroniser and a small majority filter, so a single-sample glitch is removed. The block then looks for bus conditions. A falling data line while the clock line is high marks a START. If that START arrives while a transfer is already open, the block reports it as a repeated START instead. A rising data line while the clock line is high marks a STOP.

Each condition is reported on its own one-cycle pulse. A busy level rises on the first START and stays high through any repeated START. After a STOP, busy falls only once a programmable number of idle cycles has passed. If a new START arrives during that wait, the wait is cancelled and busy stays high.

Inside an open transfer, the block samples the data line on every rising clock-line edge. The first eight bits form a byte, most significant bit first, and the ninth bit is the acknowledge bit. After the ninth bit the block presents the byte and the acknowledge bit with a one-cycle valid pulse. A STOP that arrives partway through a byte throws those bits away and reports nothing for them.

Top module: `i2c_bus_watch`

## Requirements
- R1: After reset, every pulse output is 0, `busy` is 0, `rx_byte` is 0 and `rx_ack` is 1.
- R2: A falling data line while the clock line is high, with no transfer open, gives exactly one `ev_start` pulse, and `busy` is 1 afterwards.
- R3: A falling data line while the clock line is high, inside an open transfer, gives one `ev_rstart` pulse and no `ev_start` pulse, and `busy` does not fall.
- R4: A rising data line while the clock line is high gives exactly one `ev_stop` pulse and closes the transfer.
- R5: `busy` falls exactly `free_cycles`+1 clock cycles after the cycle in which `ev_stop` is high, and stays high until then.
- R6: A START that arrives before the bus-free wait has run out cancels the wait. `busy` stays high with no low cycle, and the START is reported on `ev_start`.
- R7: Bits are sampled on rising clock-line edges, with the first bit as the most significant. After the ninth rising edge, `rx_valid` pulses for one cycle, `rx_byte` holds the eight bits, and `rx_ack` holds the ninth bit (0 means acknowledged, 1 means not acknowledged).
- R8: Every START and repeated START clears the bit count. Bits seen before a repeated START do not shift the alignment of the next byte.
- R9: A STOP in the middle of a byte produces no `rx_valid` for that partial byte.
- R10: A glitch on either line that lasts one system clock produces no condition and no extra bit.
- R11: Clock-line activity while no transfer is open produces no `rx_valid`.
- R12: At most one of `ev_start`, `ev_rstart` and `ev_stop` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as sampled |
| sda_in | input | 1 | Bus data line as sampled |
| free_cycles | input | FREE_W | Idle cycles that must follow a STOP before busy falls |
| ev_start | output | 1 | One-cycle pulse on a START |
| ev_rstart | output | 1 | One-cycle pulse on a repeated START |
| ev_stop | output | 1 | One-cycle pulse on a STOP |
| busy | output | 1 | Bus is taken |
| rx_valid | output | 1 | One-cycle pulse when a byte and its acknowledge bit are complete |
| rx_byte | output | 8 | Last complete byte |
| rx_ack | output | 1 | Acknowledge bit of the last byte (0 means acknowledged) |

## Verification
A line change reaches the outputs after a fixed pipeline delay of a few clocks. The bench therefore holds every bus phase for eight system clocks, and it reads condition pulses and bytes only after a whole transfer has settled. A monitor samples the outputs on falling clock edges and logs each pulse and each byte with its acknowledge bit, so no check depends on the exact latency. The bus-free time is the one result that depends on an exact cycle: the monitor counts the falling edges from the cycle in which `ev_stop` is seen to the first cycle in which `busy` is low, and the bench expects exactly `free_cycles`+1.

// File: rtl/i2c_bw_pkg.sv
package i2c_bw_pkg;
   localparam int unsigned BYTE_BITS = 8;
   localparam int unsigned SLOT_BITS = BYTE_BITS + 1;
   localparam int unsigned CNT_W     = $clog2(SLOT_BITS + 1);
endpackage

// File: rtl/i2c_bw_filter.sv
module i2c_bw_filter #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          MAJORITY    = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw,
   output logic clean
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sy <= '1;
      else        sy <= {sy[SYNC_STAGES-2:0], raw};
   end

   generate
      if (MAJORITY) begin : g_vote
         logic [2:0] win;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               win   <= 3'b111;
               clean <= 1'b1;
            end else begin
               win   <= {win[1:0], sy[SYNC_STAGES-1]};
               clean <= (win[0] & win[1]) | (win[0] & win[2]) | (win[1] & win[2]);
            end
         end
         // R10: the filtered level only moves once two window samples agree on it
         assert_vote_agrees_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (clean != $past(clean)) |-> ($past(win[0]) == clean || $past(win[1]) == clean));
      end else begin : g_plain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) clean <= 1'b1;
            else        clean <= sy[SYNC_STAGES-1];
         end
      end
   endgenerate
endmodule

// File: rtl/i2c_bw_events.sv
module i2c_bw_events (
   input  logic clk,
   input  logic rst_n,
   input  logic scl,
   input  logic sda,
   output logic cond_start,
   output logic cond_stop,
   output logic scl_rise
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl;
         sda_q <= sda;
      end
   end

   assign cond_start = scl & scl_q & sda_q & ~sda;
   assign cond_stop  = scl & scl_q & ~sda_q & sda;
   assign scl_rise   = scl & ~scl_q;
endmodule

// File: rtl/i2c_bw_busy.sv
module i2c_bw_busy #(
   parameter int unsigned FREE_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cond_start,
   input  logic              cond_stop,
   input  logic [FREE_W-1:0] free_cycles,
   output logic              in_frame,
   output logic              busy,
   output logic              ev_start,
   output logic              ev_rstart,
   output logic              ev_stop
);
   generate
      if (FREE_W < 1) begin : g_bad_w
         $error("FREE_W must be at least 1");
      end
   endgenerate

   logic              waiting;
   logic [FREE_W-1:0] wait_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_frame  <= 1'b0;
         busy      <= 1'b0;
         waiting   <= 1'b0;
         wait_cnt  <= '0;
         ev_start  <= 1'b0;
         ev_rstart <= 1'b0;
         ev_stop   <= 1'b0;
      end else begin
         ev_start  <= cond_start & ~in_frame;
         ev_rstart <= cond_start & in_frame;
         ev_stop   <= cond_stop;
         if (cond_start) begin
            in_frame <= 1'b1;
            busy     <= 1'b1;
            waiting  <= 1'b0;
         end else if (cond_stop) begin
            in_frame <= 1'b0;
            waiting  <= 1'b1;
            wait_cnt <= free_cycles;
         end else if (waiting) begin
            if (wait_cnt == '0) begin
               busy    <= 1'b0;
               waiting <= 1'b0;
            end else begin
               wait_cnt <= wait_cnt - 1'b1;
            end
         end
      end
   end

   assert_busy_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ev_start |-> busy);
   assert_rstart_keeps_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ev_rstart |=> busy);
   assert_stop_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ev_stop |=> !ev_stop);
   assert_busy_held_in_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_frame && busy) |=> busy);
endmodule

// File: rtl/i2c_bw_bytes.sv
module i2c_bw_bytes
   import i2c_bw_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cond_start,
   input  logic                 cond_stop,
   input  logic                 scl_rise,
   input  logic                 sda,
   input  logic                 in_frame,
   output logic                 rx_valid,
   output logic [BYTE_BITS-1:0] rx_byte,
   output logic                 rx_ack
);
   logic [CNT_W-1:0]     bit_cnt;
   logic [BYTE_BITS-1:0] shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt  <= '0;
         shreg    <= '0;
         rx_valid <= 1'b0;
         rx_byte  <= '0;
         rx_ack   <= 1'b1;
      end else begin
         rx_valid <= 1'b0;
         if (cond_start || cond_stop) begin
            bit_cnt <= '0;
         end else if (scl_rise && in_frame) begin
            if (bit_cnt == CNT_W'(BYTE_BITS)) begin
               bit_cnt  <= '0;
               rx_valid <= 1'b1;
               rx_byte  <= shreg;
               rx_ack   <= sda;
            end else begin
               shreg   <= {shreg[BYTE_BITS-2:0], sda};
               bit_cnt <= bit_cnt + 1'b1;
            end
         end
      end
   end

   assert_count_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
      bit_cnt <= CNT_W'(BYTE_BITS));
   assert_valid_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);
   assert_no_byte_outside_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> $past(in_frame));
endmodule

// File: rtl/i2c_bus_watch.sv
module i2c_bus_watch
   import i2c_bw_pkg::*;
#(
   parameter int unsigned FREE_W      = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          MAJORITY    = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 scl_in,
   input  logic                 sda_in,
   input  logic [FREE_W-1:0]    free_cycles,
   output logic                 ev_start,
   output logic                 ev_rstart,
   output logic                 ev_stop,
   output logic                 busy,
   output logic                 rx_valid,
   output logic [BYTE_BITS-1:0] rx_byte,
   output logic                 rx_ack
);
   logic scl_f, sda_f;
   logic cond_start, cond_stop, scl_rise, in_frame;

   i2c_bw_filter #(.SYNC_STAGES(SYNC_STAGES), .MAJORITY(MAJORITY)) u_scl_flt (
      .clk(clk), .rst_n(rst_n), .raw(scl_in), .clean(scl_f));
   i2c_bw_filter #(.SYNC_STAGES(SYNC_STAGES), .MAJORITY(MAJORITY)) u_sda_flt (
      .clk(clk), .rst_n(rst_n), .raw(sda_in), .clean(sda_f));

   i2c_bw_events u_ev (
      .clk(clk), .rst_n(rst_n), .scl(scl_f), .sda(sda_f),
      .cond_start(cond_start), .cond_stop(cond_stop), .scl_rise(scl_rise));

   i2c_bw_busy #(.FREE_W(FREE_W)) u_busy (
      .clk(clk), .rst_n(rst_n), .cond_start(cond_start), .cond_stop(cond_stop),
      .free_cycles(free_cycles), .in_frame(in_frame), .busy(busy),
      .ev_start(ev_start), .ev_rstart(ev_rstart), .ev_stop(ev_stop));

   i2c_bw_bytes u_bytes (
      .clk(clk), .rst_n(rst_n), .cond_start(cond_start), .cond_stop(cond_stop),
      .scl_rise(scl_rise), .sda(sda_f), .in_frame(in_frame),
      .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_ack(rx_ack));

   assert_events_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ev_start, ev_rstart, ev_stop}));
   assert_stop_no_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ev_stop |-> !rx_valid);
endmodule

// File: tb/tb_i2c_bus_watch.sv
`timescale 1ns/1ps
module tb_i2c_bus_watch;
   localparam int Q = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scl = 1'b1, sda = 1'b1;
   logic [15:0] free_cycles = 16'd0;
   logic        ev_start, ev_rstart, ev_stop, busy, rx_valid, rx_ack;
   logic [7:0]  rx_byte;

   always #5 clk = ~clk;

   i2c_bus_watch dut (
      .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda), .free_cycles(free_cycles),
      .ev_start(ev_start), .ev_rstart(ev_rstart), .ev_stop(ev_stop), .busy(busy),
      .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_ack(rx_ack));

   int total = 0, bad = 0;
   bit done = 0;
   int n_start = 0, n_rstart = 0, n_stop = 0, n_byte = 0, n_fall = 0;
   int cyc = 0, stop_cyc = 0, drop_delay = -1;
   logic [7:0] log_d [0:1023];
   logic       log_a [0:1023];
   logic       busy_q = 1'b0;

   always @(negedge clk) if (rst_n) begin
      cyc++;
      if (ev_start)  n_start++;
      if (ev_rstart) n_rstart++;
      if (ev_stop) begin n_stop++; stop_cyc = cyc; end
      if (rx_valid) begin
         log_d[n_byte & 1023] = rx_byte;
         log_a[n_byte & 1023] = rx_ack;
         n_byte++;
      end
      if (busy_q && !busy) begin n_fall++; drop_delay = cyc - stop_cyc; end
      busy_q = busy;
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wq(); repeat (Q) @(posedge clk); #1; endtask
   task automatic do_start(); sda = 1'b0; wq(); scl = 1'b0; wq(); endtask
   task automatic do_rstart(); sda = 1'b1; wq(); scl = 1'b1; wq(); sda = 1'b0; wq(); scl = 1'b0; wq(); endtask
   task automatic do_stop(); sda = 1'b0; wq(); scl = 1'b1; wq(); sda = 1'b1; wq(); wq(); endtask
   task automatic do_bit(input logic b); sda = b; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq(); endtask
   task automatic do_byte(input logic [7:0] d, input logic a);
      for (int i = 7; i >= 0; i--) do_bit(d[i]);
      do_bit(a);
   endtask
   task automatic settle(input int extra); repeat (extra + 30) @(posedge clk); #1; endtask

   function automatic bit byte_ok(input int idx, input logic [7:0] d, input logic a);
      return (log_d[idx & 1023] == d) && (log_a[idx & 1023] == a);
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         bad++; total++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int s0, r0, p0, b0, f0;
      logic [7:0] d;
      logic a;
      void'($urandom(32'h5eed_1234));
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state
      check(!ev_start && !ev_rstart && !ev_stop && !busy && !rx_valid, "R1 pulses/busy", busy, 0);
      check(rx_byte == 8'h00 && rx_ack == 1'b1, "R1 byte/ack", {rx_byte, rx_ack}, 1);
      rst_n = 1'b1;
      settle(0);

      // R10: one-cycle glitch on the data line while idle
      s0 = n_start; p0 = n_stop;
      @(posedge clk); #1; sda = 1'b0; @(posedge clk); #1; sda = 1'b1;
      @(posedge clk); #1; scl = 1'b0; @(posedge clk); #1; scl = 1'b1;
      settle(0);
      check(n_start == s0 && n_stop == p0 && !busy, "R10 idle glitch", n_start - s0 + n_stop - p0, 0);

      // R11: clock activity with no transfer open
      b0 = n_byte;
      scl = 1'b0; wq();
      do_byte(8'hA5, 1'b0);
      sda = 1'b1; wq(); scl = 1'b1; wq();
      settle(0);
      check(n_byte == b0, "R11 no byte outside frame", n_byte - b0, 0);
      check(!busy, "R11 busy stays low", busy, 0);

      // R2 / R10: transfer with a one-cycle clock-line glitch in a low phase
      free_cycles = 16'd3;
      s0 = n_start; b0 = n_byte;
      do_start();
      check(busy == 1'b1, "R2 busy after start", busy, 1);
      check(n_start == s0 + 1, "R2 one start pulse", n_start - s0, 1);
      for (int i = 7; i >= 5; i--) do_bit(1'b1);
      sda = 1'b0; @(posedge clk); #1; scl = 1'b1; @(posedge clk); #1; scl = 1'b0; wq();
      for (int i = 4; i >= 0; i--) do_bit(1'b0);
      do_bit(1'b1);
      do_stop(); settle(3);
      check(n_byte == b0 + 1 && byte_ok(b0, 8'hE0, 1'b1), "R10 clock glitch ignored", log_d[b0 & 1023], 8'hE0);

      // R9: STOP after four bits
      b0 = n_byte; p0 = n_stop;
      do_start();
      for (int i = 0; i < 4; i++) do_bit(1'b0);
      do_stop(); settle(3);
      check(n_byte == b0, "R9 partial byte dropped", n_byte - b0, 0);
      check(n_stop == p0 + 1, "R4 single stop pulse", n_stop - p0, 1);

      // R8: three bits, then repeated START, then one aligned byte
      b0 = n_byte; r0 = n_rstart; s0 = n_start;
      do_start();
      for (int i = 0; i < 3; i++) do_bit(1'b1);
      do_rstart();
      do_byte(8'h3C, 1'b0);
      do_stop(); settle(3);
      check(n_byte == b0 + 1 && byte_ok(b0, 8'h3C, 1'b0), "R8 realign after rstart", log_d[b0 & 1023], 8'h3C);
      check(n_rstart == r0 + 1 && n_start == s0 + 1, "R3 rstart classified", n_rstart - r0, 1);

      // R6: new START during the bus-free wait
      free_cycles = 16'd40;
      f0 = n_fall; s0 = n_start; r0 = n_rstart;
      do_start(); do_byte(8'h81, 1'b0); do_stop();
      repeat (5) @(posedge clk); #1;
      do_start(); do_byte(8'h18, 1'b1); do_stop();
      settle(40);
      check(n_fall == f0 + 1, "R6 no busy gap", n_fall - f0, 1);
      check(n_start == s0 + 2 && n_rstart == r0, "R6 start after stop", n_start - s0, 2);
      check(drop_delay == 41, "R5 free delay 40", drop_delay, 41);

      // R5: zero delay
      free_cycles = 16'd0;
      do_start(); do_byte(8'h55, 1'b0); do_stop(); settle(0);
      check(drop_delay == 1, "R5 free delay 0", drop_delay, 1);

      // R3 R4 R5 R7: random transfers
      for (int t = 0; t < 30; t++) begin
         int nb, rs, fc;
         logic [7:0] ed [0:7];
         logic       ea [0:7];
         nb = 1 + int'($urandom % 3);
         rs = int'($urandom % 2);
         fc = int'($urandom % 12);
         free_cycles = 16'(fc);
         s0 = n_start; r0 = n_rstart; p0 = n_stop; b0 = n_byte; f0 = n_fall;
         do_start();
         for (int k = 0; k < nb; k++) begin
            d = 8'($urandom); a = 1'($urandom);
            ed[k] = d; ea[k] = a;
            do_byte(d, a);
         end
         if (rs != 0) begin
            do_rstart();
            d = 8'($urandom); a = 1'($urandom);
            ed[nb] = d; ea[nb] = a;
            do_byte(d, a);
         end
         check(busy == 1'b1, "R3 busy through transfer", busy, 1);
         do_stop(); settle(fc);
         check(n_start == s0 + 1 && n_rstart == r0 + rs && n_stop == p0 + 1,
               "R3/R4 event counts", n_rstart - r0, rs);
         check(n_byte == b0 + nb + rs, "R7 byte count", n_byte - b0, nb + rs);
         for (int k = 0; k < nb + rs; k++)
            check(byte_ok(b0 + k, ed[k], ea[k]), "R7 byte/ack value",
                  {log_d[(b0 + k) & 1023], log_a[(b0 + k) & 1023]}, {ed[k], ea[k]});
         check(n_fall == f0 + 1 && drop_delay == fc + 1, "R5 bus-free delay", drop_delay, fc + 1);
         check(!busy, "R5 busy low after wait", busy, 0);
      end

      if (!done) begin
         done = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule